// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block moves frames between two rings of buffer descriptors and a pair of abstract frame ports. The descriptors live in a small local memory, and each one is a 64-bit word: a 16-bit status/control field, a 16-bit length field and a 32-bit buffer address. Software fills descriptors through a plain memory port. It hands a descriptor to the engine by setting the ownership bit. It then writes the receive or transmit "poll" register, which makes the engine walk that ring.

On the transmit side, each owned descriptor is presented on a request/acknowledge port. Once the frame is acknowledged, the engine writes the descriptor back with ownership cleared and the retry count recorded. On the receive side, each free descriptor offers its buffer address on the receive port. When a frame arrives, the engine writes back the received length and the error flags, and clears ownership. One engine serves both rings through a single memory port, and transmit work takes precedence.

A descriptor with the ring-end bit set sends the ring index back to zero. When the engine finds a descriptor it does not own, it drops that ring's active flag and waits for the next poll write. The two rings can be placed anywhere in the memory through per-ring start indices.

Top module: `bdring_seq`

## Requirements
- R1: After reset, `rx_active`, `tx_active`, `tx_req` and `rx_ready` are low, and both ring indices are 0.
- R2: A write to a poll register starts that ring only when bit 24 of `act_wdata` is set (value 0x01000000). A write with bit 24 clear has no effect.
- R3: For a transmit descriptor whose ownership bit (status bit 15) is set, `tx_req` rises. It presents the descriptor's address and length, with `tx_last` taken from status bit 11 and `tx_crc` from status bit 10, and all of these hold steady until `tx_ack`.
- R4: After `tx_ack`, the transmit descriptor is written back with bit 15 cleared and bits 5:2 replaced by `tx_retry`. All other status bits, the length and the address are unchanged.
- R5: For a receive descriptor with bit 15 set, `rx_ready` rises and `rx_addr` shows its buffer address. On `rx_valid`, the descriptor is written back with the received length (FCS included), bit 15 cleared, bits 15:6 otherwise kept, and bits 5:0 set to `rx_err`.
- R6: A received length above 1518 sets status bit 5. A length above 1520 is written back as 1520.
- R7: After a descriptor with status bit 13 (ring end) is consumed, that ring's next descriptor is index 0.
- R8: Polling a descriptor without bit 15 clears that ring's active flag and starts no transfer. A later poll write resumes at the same index.
- R9: While `en` is low, both active flags are cleared and both indices are forced to 0, and poll writes are ignored.
- R10: Transmit work goes first. A receive wait with no frame yields to a pending transmit ring.
- R11: A software memory write has priority over an engine write-back in the same cycle. The write-back waits and lands afterwards, and both writes survive.
- R12: A descriptor is fetched from memory index `start + ring index` of its ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; low clears flags and indices |
| rx_start | input | AW | Memory index of receive descriptor 0 |
| tx_start | input | AW | Memory index of transmit descriptor 0 |
| act_rx_wr | input | 1 | Write strobe of receive poll register |
| act_tx_wr | input | 1 | Write strobe of transmit poll register |
| act_wdata | input | 32 | Poll register write data (bit 24 starts) |
| sw_we | input | 1 | Software descriptor write enable |
| sw_addr | input | AW | Software descriptor index |
| sw_wdata | input | 64 | Descriptor word {status, length, address} |
| sw_rdata | output | 64 | Registered descriptor read data |
| rx_active | output | 1 | Receive ring polling |
| tx_active | output | 1 | Transmit ring polling |
| tx_req | output | 1 | Transmit buffer offered |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit buffer length |
| tx_last | output | 1 | Buffer ends a frame |
| tx_crc | output | 1 | Append CRC |
| tx_ack | input | 1 | Transmit of buffer finished |
| tx_retry | input | 4 | Retry count for the finished buffer |
| rx_ready | output | 1 | Receive buffer available |
| rx_addr | output | 32 | Receive buffer address |
| rx_valid | input | 1 | Frame received |
| rx_len | input | 16 | Received length including FCS |
| rx_err | input | 6 | Receive error flags |

## Verification
The bench targets the ring-end wrap, resuming after an unowned descriptor, index clearing on re-enable, ignored poll writes, and length clamping just above each of the two limits. A design that got these wrong would, in order: run past the ring end into foreign descriptors; skip or repeat a descriptor; restart from a stale index; start polling on a wrong register value; or write back an unflagged or oversized length. It also collides a software write with an engine write-back, where a wrong design loses one of the two words. It parks the receive side while a transmit arrives, where a wrong design deadlocks the transmit ring. Random frames with random lengths, error flags, retry counts and control bits check the write-back field merging.

// File: rtl/bdring_pkg.sv
package bdring_pkg;
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_LAST = 11;
  localparam int ST_CRC  = 10;

  typedef struct packed {
    logic [15:0] st;
    logic [15:0] len;
    logic [31:0] addr;
  } desc_t;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_TX, S_RX, S_WB} eng_state_t;
endpackage

// File: rtl/bdring_mem.sv
module bdring_mem #(
  parameter int AW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata_a <= ram[raddr_a];
    rdata_b <= ram[raddr_b];
  end
endmodule

// File: rtl/bdring_idx.sv
module bdring_idx #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (clr)      idx <= '0;
    else if (adv) idx <= wrap ? '0 : idx + 1'b1;
  end

  // R7: consuming a ring-end descriptor returns the index to zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (clr)
    (adv && wrap) |=> (idx == '0));
endmodule

// File: rtl/bdring_seq.sv
module bdring_seq
  import bdring_pkg::*;
#(
  parameter int AW        = 4,
  parameter int BUF_SIZE  = 1520,
  parameter int MAX_FRAME = 1518,
  parameter int START_BIT = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] rx_start,
  input  logic [AW-1:0] tx_start,
  input  logic          act_rx_wr,
  input  logic          act_tx_wr,
  input  logic [31:0]   act_wdata,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [63:0]   sw_wdata,
  output logic [63:0]   sw_rdata,
  output logic          rx_active,
  output logic          tx_active,
  output logic          tx_req,
  output logic [31:0]   tx_addr,
  output logic [15:0]   tx_len,
  output logic          tx_last,
  output logic          tx_crc,
  input  logic          tx_ack,
  input  logic [3:0]    tx_retry,
  output logic          rx_ready,
  output logic [31:0]   rx_addr,
  input  logic          rx_valid,
  input  logic [15:0]   rx_len,
  input  logic [5:0]    rx_err
);
  localparam logic [15:0] BUF_LIM   = 16'(BUF_SIZE);
  localparam logic [15:0] FRAME_LIM = 16'(MAX_FRAME);
  localparam int NDIR = 2;  // index 0 receive, 1 transmit

  eng_state_t    state;
  logic          cur_tx;
  desc_t         desc_q, wb_q;
  logic [63:0]   eng_rdata;
  logic [AW-1:0] ring_idx [NDIR];
  logic [NDIR-1:0] ring_adv;
  logic          ring_clr;
  logic [AW-1:0] eng_addr;
  logic          eng_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [63:0]   mem_wdata;
  logic          rx_set, tx_set, rx_drop, tx_drop;
  desc_t         rd_desc;

  assign rd_desc  = desc_t'(eng_rdata);
  assign ring_clr = rst | ~en;
  assign eng_addr = cur_tx ? tx_start + ring_idx[1] : rx_start + ring_idx[0];
  assign eng_we   = (state == S_WB) && !sw_we;
  assign mem_we   = sw_we | eng_we;
  assign mem_waddr = sw_we ? sw_addr : eng_addr;
  assign mem_wdata = sw_we ? sw_wdata : wb_q;

  bdring_mem #(.AW(AW), .DW(64)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(sw_addr), .rdata_a(sw_rdata),
    .raddr_b(eng_addr), .rdata_b(eng_rdata)
  );

  assign ring_adv = {eng_we & cur_tx, eng_we & ~cur_tx};

  for (genvar g = 0; g < NDIR; g++) begin : g_ring
    bdring_idx #(.AW(AW)) u_idx (
      .clk(clk), .clr(ring_clr), .adv(ring_adv[g]),
      .wrap(wb_q.st[ST_WRAP]), .idx(ring_idx[g])
    );
  end

  // poll register writes; a start in the same cycle beats a drop
  assign rx_set  = act_rx_wr && act_wdata[START_BIT];
  assign tx_set  = act_tx_wr && act_wdata[START_BIT];
  assign rx_drop = (state == S_CHK) && !cur_tx && !rd_desc.st[ST_OWN];
  assign tx_drop = (state == S_CHK) &&  cur_tx && !rd_desc.st[ST_OWN];

  always_ff @(posedge clk) begin
    if (ring_clr) begin
      rx_active <= 1'b0;
      tx_active <= 1'b0;
    end else begin
      rx_active <= rx_set | (rx_active & ~rx_drop);
      tx_active <= tx_set | (tx_active & ~tx_drop);
    end
  end

  always_ff @(posedge clk) begin
    if (ring_clr) begin
      state  <= S_IDLE;
      cur_tx <= 1'b0;
      desc_q <= '0;
      wb_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (tx_active) begin
            cur_tx <= 1'b1;
            state  <= S_RD;
          end else if (rx_active) begin
            cur_tx <= 1'b0;
            state  <= S_RD;
          end
        end
        S_RD: state <= S_CHK;
        S_CHK: begin
          desc_q <= rd_desc;
          if (rd_desc.st[ST_OWN]) state <= cur_tx ? S_TX : S_RX;
          else                    state <= S_IDLE;
        end
        S_TX: begin
          if (tx_ack) begin
            wb_q           <= desc_q;
            wb_q.st[ST_OWN] <= 1'b0;
            wb_q.st[5:2]   <= tx_retry;
            state          <= S_WB;
          end
        end
        S_RX: begin
          if (rx_valid) begin
            wb_q.addr     <= desc_q.addr;
            wb_q.len      <= (rx_len > BUF_LIM) ? BUF_LIM : rx_len;
            wb_q.st       <= {1'b0, desc_q.st[14:6],
                              rx_err[5] | (rx_len > FRAME_LIM), rx_err[4:0]};
            state         <= S_WB;
          end else if (tx_active) begin
            state <= S_IDLE;
          end
        end
        S_WB: if (!sw_we) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign tx_req   = (state == S_TX);
  assign tx_addr  = desc_q.addr;
  assign tx_len   = desc_q.len;
  assign tx_last  = desc_q.st[ST_LAST];
  assign tx_crc   = desc_q.st[ST_CRC];
  assign rx_ready = (state == S_RX);
  assign rx_addr  = desc_q.addr;

  // R2: a start write turns polling on
  a_r2_start_sets_active: assert property (@(posedge clk) disable iff (rst)
    (en && act_tx_wr && act_wdata[START_BIT]) |=> tx_active);
  // R3: an offered transmit buffer stays put until acknowledged
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst || !en)
    (tx_req && !tx_ack) |=> (tx_req && $stable(tx_addr) && $stable(tx_len)));
  // R4: a write-back never hands ownership back to the engine
  a_r4_wb_releases: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !mem_wdata[48 + ST_OWN]);
  // R9: disable clears both rings
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_active && !rx_active && !tx_req && !rx_ready));
  // R10: only one side is served at a time
  a_r10_one_side: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_req, rx_ready}));
  // R11: a pending write-back waits for the software write
  a_r11_sw_first: assert property (@(posedge clk) disable iff (rst || !en)
    (state == S_WB && sw_we) |=> (state == S_WB));
endmodule

// File: tb/bdring_seq_bench.sv
module bdring_seq_bench;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, en, act_rx_wr, act_tx_wr, sw_we, tx_ack, rx_valid;
  logic [AW-1:0] rx_start, tx_start, sw_addr;
  logic [31:0] act_wdata;
  logic [63:0] sw_wdata, sw_rdata;
  logic rx_active, tx_active, tx_req, tx_last, tx_crc, rx_ready;
  logic [31:0] tx_addr, rx_addr;
  logic [15:0] tx_len, rx_len;
  logic [3:0] tx_retry;
  logic [5:0] rx_err;

  int nchk = 0;
  int nfail = 0;

  bdring_seq #(.AW(AW)) u_bdring_seq (
    .clk(clk), .rst(rst), .en(en), .rx_start(rx_start), .tx_start(tx_start),
    .act_rx_wr(act_rx_wr), .act_tx_wr(act_tx_wr), .act_wdata(act_wdata),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .rx_active(rx_active), .tx_active(tx_active), .tx_req(tx_req),
    .tx_addr(tx_addr), .tx_len(tx_len), .tx_last(tx_last), .tx_crc(tx_crc),
    .tx_ack(tx_ack), .tx_retry(tx_retry), .rx_ready(rx_ready), .rx_addr(rx_addr),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err)
  );

  function automatic logic [63:0] mk(input logic [15:0] st, input logic [15:0] ln,
                                     input logic [31:0] a);
    return {st, ln, a};
  endfunction

  function automatic logic [63:0] exp_rx(input logic [63:0] armed, input logic [15:0] ln,
                                         input logic [5:0] er);
    logic [15:0] st;
    logic [15:0] wl;
    wl = (ln > 16'd1520) ? 16'd1520 : ln;
    st = (armed[63:48] & 16'h7FC0) | {10'd0, er};
    if (ln > 16'd1518) st[5] = 1'b1;
    return {st, wl, armed[31:0]};
  endfunction

  function automatic logic [63:0] exp_tx(input logic [63:0] armed, input logic [3:0] rt);
    logic [15:0] st;
    st = (armed[63:48] & ~16'h803C) | {10'd0, rt, 2'b00};
    return {st, armed[47:0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_desc(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rd_desc(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    sw_addr = a;
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic poll(input logic tx, input logic [31:0] v);
    @(negedge clk);
    act_wdata = v;
    if (tx) act_tx_wr = 1'b1; else act_rx_wr = 1'b1;
    @(negedge clk);
    act_tx_wr = 1'b0; act_rx_wr = 1'b0;
  endtask

  task automatic serve_tx(input logic [63:0] armed, input logic [3:0] rt, input string tag);
    bit seen = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (tx_req) begin seen = 1; break; end
    end
    chk(seen, {tag, " tx_req"}, 64'(tx_req), 64'd1);
    chk({tx_addr, tx_len, tx_last, tx_crc} ==
        {armed[31:0], armed[47:32], armed[48+11], armed[48+10]},
        {tag, " R3 tx fields"}, {tx_addr, tx_len, 14'd0, tx_last, tx_crc},
        {armed[31:0], armed[47:32], 14'd0, armed[59], armed[58]});
    tx_ack = 1'b1; tx_retry = rt;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  task automatic serve_rx(input logic [63:0] armed, input logic [15:0] ln,
                          input logic [5:0] er, input string tag);
    bit seen = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (rx_ready) begin seen = 1; break; end
    end
    chk(seen && rx_addr == armed[31:0], {tag, " R5 rx_addr"}, {31'd0, seen, rx_addr},
        {32'd1, armed[31:0]});
    rx_valid = 1'b1; rx_len = ln; rx_err = er;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] d, a0, a1, a2;
    int k;
    void'($urandom(32'd1234));
    rst = 1'b1; en = 1'b1; act_rx_wr = 0; act_tx_wr = 0; act_wdata = 0;
    sw_we = 0; sw_addr = 0; sw_wdata = 0; tx_ack = 0; tx_retry = 0;
    rx_valid = 0; rx_len = 0; rx_err = 0; rx_start = 4'd0; tx_start = 4'd8;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sw_we = 1'b1; sw_addr = 4'(i); sw_wdata = '0;
    end
    @(negedge clk); sw_we = 1'b0;
    idle(2);
    chk({rx_active, tx_active, tx_req, rx_ready} == 4'b0, "R1 reset outputs",
        {60'd0, rx_active, tx_active, tx_req, rx_ready}, 64'd0);
    rst = 1'b0;
    idle(2);

    // R2: a write without bit 24 is ignored
    a0 = mk(16'h8000 | 16'h0800 | 16'h0400 | 16'h0014, 16'd64, 32'h1000_0000);
    wr_desc(4'd8, a0);
    poll(1'b1, 32'h0000_0001);
    idle(10);
    chk(!tx_active && !tx_req, "R2 ignored poll", {62'd0, tx_active, tx_req}, 64'd0);
    poll(1'b1, 32'h0100_0000);
    serve_tx(a0, 4'd5, "R2 R12 first tx");
    idle(3);
    rd_desc(4'd8, d);
    chk(d == exp_tx(a0, 4'd5), "R4 tx write-back", d, exp_tx(a0, 4'd5));
    idle(10);
    chk(!tx_active && !tx_req, "R8 unowned drops active", {62'd0, tx_active, tx_req}, 64'd0);

    // R8: resume at index 1
    a1 = mk(16'h8800, 16'd200, 32'h1100_0000);
    wr_desc(4'd9, a1);
    poll(1'b1, 32'h0100_0000);
    serve_tx(a1, 4'd0, "R8 resume");
    // R11: software write collides with the write-back
    a2 = mk(16'hA000, 16'd300, 32'h1200_0000);
    wr_desc(4'd10, a2);
    poll(1'b1, 32'h0100_0000);
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (tx_req) break;
    end
    tx_ack = 1'b1; tx_retry = 4'd9;
    @(negedge clk);
    tx_ack = 1'b0; sw_we = 1'b1; sw_addr = 4'd15; sw_wdata = 64'hDEAD_BEEF_0123_4567;
    idle(4);
    sw_we = 1'b0;
    idle(3);
    rd_desc(4'd10, d);
    chk(d == exp_tx(a2, 4'd9), "R11 delayed write-back", d, exp_tx(a2, 4'd9));
    rd_desc(4'd15, d);
    chk(d == 64'hDEAD_BEEF_0123_4567, "R11 software word", d, 64'hDEAD_BEEF_0123_4567);

    // R7: after ring end, index 0 again
    a0 = mk(16'h8400, 16'd90, 32'h1300_0000);
    wr_desc(4'd8, a0);
    poll(1'b1, 32'h0100_0000);
    serve_tx(a0, 4'd1, "R7 wrap");
    idle(10);

    // R9: disable clears and ignores polls
    a1 = mk(16'h8000, 16'd77, 32'h1400_0000);
    wr_desc(4'd9, a1);
    @(negedge clk); en = 1'b0;
    poll(1'b1, 32'h0100_0000);
    idle(2);
    chk(!tx_active && !rx_active, "R9 disabled flags", {62'd0, tx_active, rx_active}, 64'd0);
    @(negedge clk); en = 1'b1;
    idle(10);
    chk(!tx_active && !tx_req, "R9 poll ignored while off", {62'd0, tx_active, tx_req}, 64'd0);
    a0 = mk(16'h8000, 16'd88, 32'h1500_0000);
    wr_desc(4'd8, a0);
    wr_desc(4'd9, 64'd0);
    poll(1'b1, 32'h0100_0000);
    serve_tx(a0, 4'd2, "R9 index restart");
    idle(10);

    // R10: parked receive yields to transmit
    d = mk(16'h8000, 16'd0, 32'h2000_0000);
    wr_desc(4'd0, d);
    poll(1'b0, 32'h0100_0000);
    idle(8);
    chk(rx_ready && rx_active, "R5 rx offered", {62'd0, rx_ready, rx_active}, 64'd3);
    a1 = mk(16'h8000, 16'd60, 32'h1600_0000);
    wr_desc(4'd9, a1);
    poll(1'b1, 32'h0100_0000);
    serve_tx(a1, 4'd3, "R10 tx over parked rx");
    serve_rx(d, 16'd100, 6'd0, "R10 rx after tx");
    idle(3);
    a0 = d;
    rd_desc(4'd0, d);
    chk(d == exp_rx(a0, 16'd100, 6'd0), "R5 rx write-back", d, exp_rx(a0, 16'd100, 6'd0));

    // R6: just above frame limit, and above buffer limit
    a0 = mk(16'h8000, 16'd0, 32'h2100_0000);
    wr_desc(4'd1, a0);
    poll(1'b0, 32'h0100_0000);
    serve_rx(a0, 16'd1519, 6'd0, "R6 long frame");
    idle(3);
    rd_desc(4'd1, d);
    chk(d == exp_rx(a0, 16'd1519, 6'd0), "R6 1519 flagged", d, exp_rx(a0, 16'd1519, 6'd0));
    a0 = mk(16'h8000, 16'd0, 32'h2200_0000);
    wr_desc(4'd2, a0);
    poll(1'b0, 32'h0100_0000);
    serve_rx(a0, 16'd1600, 6'd0, "R6 oversize");
    idle(3);
    rd_desc(4'd2, d);
    chk(d == exp_rx(a0, 16'd1600, 6'd0), "R6 clamp 1520", d, exp_rx(a0, 16'd1600, 6'd0));

    // random receive frames over a four-entry ring (R5 R7 R12)
    k = 3;
    for (int i = 0; i < 12; i++) begin
      logic [15:0] ln;
      logic [5:0] er;
      ln = 16'(40 + ($urandom % 1570));
      er = ($urandom % 2 == 0) ? 6'd0 : 6'($urandom);
      a0 = mk(16'h8000 | ((k == 3) ? 16'h2000 : 16'h0) | 16'($urandom & 32'h1FC0),
              16'($urandom), $urandom);
      a0[63] = 1'b1;
      wr_desc(4'(k), a0);
      poll(1'b0, 32'h0100_0000);
      serve_rx(a0, ln, er, "R7 random rx");
      idle(3);
      rd_desc(4'(k), d);
      chk(d == exp_rx(a0, ln, er), "R5 random rx write-back", d, exp_rx(a0, ln, er));
      k = (k == 3) ? 0 : k + 1;
    end

    // random transmit frames over a three-entry ring (R3 R4 R7)
    k = 2;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] rt;
      logic [15:0] st;
      rt = 4'($urandom);
      st = 16'h8000 | ((k == 2) ? 16'h2000 : 16'h0) | 16'($urandom & 32'h0C3C);
      a0 = mk(st, 16'($urandom % 1519), $urandom);
      wr_desc(4'(8 + k), a0);
      poll(1'b1, 32'h0100_0000);
      serve_tx(a0, rt, "R7 random tx");
      idle(3);
      rd_desc(4'(8 + k), d);
      chk(d == exp_tx(a0, rt), "R4 random tx write-back", d, exp_tx(a0, rt));
      k = (k == 2) ? 0 : k + 1;
    end

    idle(5);
    finish_run();
  end
endmodule